// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits next to an integer adder/subtractor and turns its operands, result and carry outputs into the six arithmetic status flags: carry, parity, half-carry, zero, sign and overflow. A size selector picks an 8-, 16- or 32-bit view of the operation. The size decides which bit is read as the sign, which carry from the adder becomes the carry flag, and how many result bits take part in the zero test. A logic-operation mode covers AND/OR/XOR style results. In that mode the three carry-derived flags are cleared, and the result-derived flags still follow the result.

Operations arrive on a valid/ready stream and the flags leave on a second valid/ready stream. One register stage sits between them. An input is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so the block runs at one operation per cycle when the consumer keeps `out_ready` high. While `out_valid` is high and `out_ready` is low, the output flags are frozen and no new input is taken.

Top module: `arith_flag_gen`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted input appears with `out_valid` high at the next clock edge. With no input offered and `out_ready` high, `out_valid` drops at the next edge.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every flag output keeps its value, whatever changes on the inputs.
- R3: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R4: `carry_in_vec[k]` is the adder's carry out of bit (8<<k)-1 (bit 0 for byte, bit 1 for word, bit 2 for dword). For addition, `flag_c` is the selected bit. For subtraction, the adder forms A + ~B + 1, so `flag_c` is the inverse of the selected bit (the borrow).
- R5: `flag_p` is 1 when `op_res[7:0]` holds an even number of one bits and 0 when the count is odd, at every size.
- R6: `flag_a` is the carry from bit 3 into bit 4 on addition and the borrow into bit 4 on subtraction, formed as `op_a[4]^op_b[4]^op_res[4]`.
- R7: `flag_z` is 1 exactly when all result bits inside the selected size are 0. Result bits above the size are ignored.
- R8: `flag_s` equals the top result bit of the selected size: bit 7, 15 or 31.
- R9: On addition, `flag_o` is 1 when the operand sign bits at the selected size are equal and the result sign bit differs from them.
- R10: On subtraction, `flag_o` is 1 when the operand sign bits at the selected size differ and the result sign bit differs from that of `op_a`.
- R11: When `is_logic` is 1, `flag_c`, `flag_o` and `flag_a` are 0 whatever the carries and `is_sub` are, and `flag_z`, `flag_s` and `flag_p` follow the result as in R5, R7 and R8.
- R12: `op_size` encodes 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = 32-bit, and the spare code 2'b11 behaves as 32-bit. Operand and result bits above the selected size affect no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_res | input | 32 | Adder/subtractor or logic result |
| carry_in_vec | input | 3 | Adder carry out of bits 7, 15, 31 |
| is_sub | input | 1 | 1 = subtraction, 0 = addition |
| is_logic | input | 1 | 1 = logic operation |
| op_size | input | 2 | Operand size code |
| out_valid | output | 1 | Flags are presented |
| out_ready | input | 1 | Consumer takes the flags this cycle |
| flag_c | output | 1 | Carry / borrow |
| flag_p | output | 1 | Even parity of low result byte |
| flag_a | output | 1 | Half-carry at bit 4 |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Result sign |
| flag_o | output | 1 | Signed overflow |

## Verification
The only state is the output register and its valid bit. A wrong value in either shows up at the ports in the cycle right after the accepting edge, as a wrong flag or a wrong `out_valid`/`in_ready` pair. A selection fault, such as the wrong size slice, a swapped carry polarity or a missing logic mask, shows only for operand pairs that reach the affected bit. For that reason the byte size is swept over every operand pair for both add and subtract, with nonzero upper bits. The wider sizes and the spare size code are driven with a set of boundary values around each sign bit. A hold fault appears within the first stalled cycle as a flag that changes while `out_ready` is low.

// File: rtl/asf_pkg.sv
package asf_pkg;
  localparam int BASE_W  = 8;
  localparam int NUM_SZ  = 3;
  localparam int SZ_SEL_W = 2;

  typedef enum logic [SZ_SEL_W-1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_SPARE = 2'b11
  } size_e;

  typedef struct packed {
    logic c;
    logic p;
    logic a;
    logic z;
    logic s;
    logic o;
  } flags_t;
endpackage

// File: rtl/asf_parity.sv
module asf_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  output logic         even
);
  // XOR-reduce: 0 for even count, so invert to flag even parity.
  always_comb even = ~(^data);
endmodule

// File: rtl/asf_size_slice.sv
module asf_size_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_part,
  input  logic         a_msb,
  input  logic         b_msb,
  input  logic         cout,
  input  logic         is_sub,
  output logic         zero,
  output logic         sign,
  output logic         ovf,
  output logic         cy
);
  logic same_in;
  logic res_flip;

  always_comb begin
    zero     = ~|res_part;
    sign     = res_part[W-1];
    same_in  = (a_msb == b_msb);
    res_flip = (sign != a_msb);
    // Add: like signs producing other sign. Sub: unlike signs, sign leaves A's.
    ovf      = is_sub ? (!same_in && res_flip) : (same_in && res_flip);
    // Subtraction runs as A + ~B + 1: carry high means no borrow.
    cy       = cout ^ is_sub;
  end
endmodule

// File: rtl/asf_flag_core.sv
module asf_flag_core
  import asf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [DATA_W-1:0]   op_res,
  input  logic [NUM_SZ-1:0]   carry_in_vec,
  input  logic                is_sub,
  input  logic                is_logic,
  input  logic [SZ_SEL_W-1:0] op_size,
  output flags_t              flags
);
  localparam int HALF_BIT = BASE_W / 2;

  logic [NUM_SZ-1:0] z_v, s_v, o_v, c_v;
  logic              par_even;
  logic [SZ_SEL_W-1:0] sel;

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_slice
    localparam int SW = BASE_W << k;
    asf_size_slice #(.W(SW)) u_slice (
      .res_part (op_res[SW-1:0]),
      .a_msb    (op_a[SW-1]),
      .b_msb    (op_b[SW-1]),
      .cout     (carry_in_vec[k]),
      .is_sub   (is_sub),
      .zero     (z_v[k]),
      .sign     (s_v[k]),
      .ovf      (o_v[k]),
      .cy       (c_v[k])
    );
  end

  asf_parity #(.W(BASE_W)) u_par (
    .data (op_res[BASE_W-1:0]),
    .even (par_even)
  );

  always_comb begin
    // Codes past the last size fall back to the widest slice.
    if (int'(op_size) >= NUM_SZ) sel = SZ_SEL_W'(NUM_SZ - 1);
    else                         sel = op_size;
    flags.z = z_v[sel];
    flags.s = s_v[sel];
    flags.p = par_even;
    flags.c = is_logic ? 1'b0 : c_v[sel];
    flags.o = is_logic ? 1'b0 : o_v[sel];
    flags.a = is_logic ? 1'b0
                       : (op_a[HALF_BIT] ^ op_b[HALF_BIT] ^ op_res[HALF_BIT]);
  end
endmodule

// File: rtl/asf_out_stage.sv
module asf_out_stage
  import asf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  output logic   in_ready,
  input  flags_t in_flags,
  output logic   out_valid,
  input  logic   out_ready,
  output flags_t out_flags
);
  always_comb in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flags <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_flags <= in_flags;
    end
  end

  // R2
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flags)));

  // R1
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R1
  drain_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/arith_flag_gen.sv
module arith_flag_gen
  import asf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [DATA_W-1:0]   op_res,
  input  logic [NUM_SZ-1:0]   carry_in_vec,
  input  logic                is_sub,
  input  logic                is_logic,
  input  logic [SZ_SEL_W-1:0] op_size,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                flag_c,
  output logic                flag_p,
  output logic                flag_a,
  output logic                flag_z,
  output logic                flag_s,
  output logic                flag_o
);
  flags_t next_flags;
  flags_t held_flags;

  asf_flag_core #(.DATA_W(DATA_W)) u_core (
    .op_a         (op_a),
    .op_b         (op_b),
    .op_res       (op_res),
    .carry_in_vec (carry_in_vec),
    .is_sub       (is_sub),
    .is_logic     (is_logic),
    .op_size      (op_size),
    .flags        (next_flags)
  );

  asf_out_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_flags  (next_flags),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_flags (held_flags)
  );

  always_comb begin
    flag_c = held_flags.c;
    flag_p = held_flags.p;
    flag_a = held_flags.a;
    flag_z = held_flags.z;
    flag_s = held_flags.s;
    flag_o = held_flags.o;
  end

  // R11
  logic_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && is_logic) |=> (!flag_c && !flag_o && !flag_a));

  // R7
  all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (op_res == '0)) |=> (flag_z && flag_p && !flag_s));

  // R8
  dword_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (op_size == SZ_DWORD)) |=> (flag_s == $past(op_res[DATA_W-1])));

  // R3
  always_comb begin
    if (!rst_n) reset_ready_chk: assert (in_ready);
  end
endmodule

// File: tb/arith_flag_gen_tb.sv
`timescale 1ns/1ps
module arith_flag_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0, op_b = '0, op_res = '0;
  logic [2:0]  carry_in_vec = '0;
  logic        is_sub = 1'b0, is_logic = 1'b0;
  logic [1:0]  op_size = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        flag_c, flag_p, flag_a, flag_z, flag_s, flag_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic pend = 0;
  logic e_c, e_p, e_a, e_z, e_s, e_o, e_sub;

  always #4 clk = ~clk;

  arith_flag_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .op_res(op_res), .carry_in_vec(carry_in_vec),
    .is_sub(is_sub), .is_logic(is_logic), .op_size(op_size),
    .out_valid(out_valid), .out_ready(out_ready),
    .flag_c(flag_c), .flag_p(flag_p), .flag_a(flag_a),
    .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic check_out();
    chk(out_valid, 1'b1, "R1 out_valid after accept");
    chk(flag_c, e_c, e_sub ? "R4 carry (sub) / R11" : "R4 carry (add) / R11");
    chk(flag_p, e_p, "R5 parity");
    chk(flag_a, e_a, "R6 half-carry / R11");
    chk(flag_z, e_z, "R7 zero / R12");
    chk(flag_s, e_s, "R8 sign / R12");
    chk(flag_o, e_o, e_sub ? "R10 overflow sub / R11" : "R9 overflow add / R11");
  endtask

  // Streams one operation per cycle: checks the previous one, then drives this one.
  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic sub, input logic lg, input logic [1:0] sz);
    int w;
    logic [31:0] m, r;
    logic [2:0] cv;
    logic [63:0] t;
    longint sa, sb, sr, lim;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    for (int k = 0; k < 3; k++) begin
      int wk;
      logic [31:0] mk;
      wk = 8 << k;
      mk = (wk == 32) ? 32'hFFFF_FFFF : ((32'h1 << wk) - 32'h1);
      if (sub) cv[k] = ((a & mk) >= (b & mk));
      else begin
        t = 64'(a & mk) + 64'(b & mk);
        cv[k] = t[wk];
      end
    end
    if (lg) begin
      r  = a ^ b;
      cv = 3'b101;
    end else r = sub ? (a - b) : (a + b);
    sa = longint'(a & m); if (a[w-1]) sa -= (longint'(1) << w);
    sb = longint'(b & m); if (b[w-1]) sb -= (longint'(1) << w);
    sr = sub ? (sa - sb) : (sa + sb);
    lim = longint'(1) << (w - 1);
    @(negedge clk);
    if (pend) check_out();
    chk(in_ready, 1'b1, "R1 ready while draining");
    e_sub = sub && !lg;
    if (lg) begin e_c = 0; e_a = 0; e_o = 0; end
    else begin
      t = 64'(a & m) + 64'(b & m);
      e_c = sub ? ((a & m) < (b & m)) : t[w];
      e_a = sub ? ((a & 32'hF) < (b & 32'hF)) : (((a & 32'hF) + (b & 32'hF)) >= 32'h10);
      e_o = (sr >= lim) || (sr < -lim);
    end
    e_z = ((r & m) == 32'h0);
    e_s = r[w-1];
    e_p = ~(^r[7:0]);
    op_a = a; op_b = b; op_res = r; carry_in_vec = cv;
    is_sub = sub; is_logic = lg; op_size = sz; in_valid = 1'b1;
    pend = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) check_out();
    pend = 0;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid, 1'b0, "R1 out_valid drops when idle");
  endtask

  logic [31:0] pats [16] = '{32'h0, 32'h1, 32'hF, 32'h10, 32'h7F, 32'h80, 32'hFF,
                             32'h7FFF, 32'h8000, 32'hFFFF, 32'h7FFF_FFFF,
                             32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
                             32'hDEAD_BEEF, 32'h0000_FFF0};

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid, 1'b0, "R3 out_valid in reset");
    chk(in_ready, 1'b1, "R3 in_ready in reset");
    rst_n = 1'b1;

    // R4 R5 R6 R7 R8 R9 R10 R12: every byte pair, add and subtract, noisy upper bits.
    for (int s = 0; s < 2; s++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++)
          issue({24'(x * 40503 + y * 97), 8'(x)}, {24'(y * 2654 + x), 8'(y)},
                logic'(s), 1'b0, 2'd0);

    // Wider sizes and the spare code, arithmetic and logic modes (R11, R12).
    for (int sz = 1; sz < 4; sz++)
      for (int lg = 0; lg < 2; lg++)
        for (int s = 0; s < 2; s++)
          for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
              issue(pats[i], pats[j], logic'(s), logic'(lg), 2'(sz));
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        issue(pats[i], pats[j], 1'b1, 1'b1, 2'd0);
    flush();

    // R2: stall with changing inputs; 0x80+0x80 byte -> C=1 Z=1 O=1 P=1 A=0 S=0.
    @(negedge clk);
    out_ready = 1'b0;
    op_a = 32'h80; op_b = 32'h80; op_res = 32'h100; carry_in_vec = 3'b001;
    is_sub = 0; is_logic = 0; op_size = 2'd0; in_valid = 1'b1;
    @(negedge clk);
    op_a = 32'h1; op_b = 32'h1; op_res = 32'h2; carry_in_vec = 3'b000;
    for (int n = 0; n < 4; n++) begin
      chk(out_valid, 1'b1, "R2 valid held");
      chk(in_ready, 1'b0, "R1 not ready while stalled");
      chk(flag_c, 1'b1, "R2 carry held");
      chk(flag_z, 1'b1, "R2 zero held");
      chk(flag_o, 1'b1, "R2 overflow held");
      chk(flag_p, 1'b1, "R2 parity held");
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(flag_c, 1'b0, "R1 next op carry");
    chk(flag_z, 1'b0, "R1 next op zero");
    chk(flag_p, 1'b0, "R1 next op parity");
    @(negedge clk);
    chk(out_valid, 1'b0, "R1 drained");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule